// File: doc/BRIEF.md
# Abortable Response Staging FIFO

This block sits between a byte-serial downstream bus engine and an upstream host-facing packetiser. The bus engine streams the bytes of each response it collects into the block. The bytes land first in a staging buffer. The final byte carries an end marker. If the bus cycle completes cleanly, the staged response is copied into an output FIFO as one unit. If the bus cycle reports an abort or a loss of synchronisation on any byte, the whole staged response is thrown away and nothing of it ever reaches the host side.

The upstream side sees a single availability flag. The flag is high only while at least one whole response is held in the output FIFO. Bytes are popped through a valid/ready stream that carries an end marker on each response's final byte. Both data edges are valid/ready streams. A transfer happens on a rising clock edge where valid and ready are both high. The input side drops ready while a commit is pending or running, and also when the staging buffer is full. The output side holds its byte steady for as long as the consumer withholds ready. Storage is 8 bits wide throughout. The staging depth bounds the longest response. All storage sizes are parameters.

Top module: `resp_stage_fifo`

## Requirements
- R1: After reset, `in_ready` is 1, and `out_valid` and `resp_avail` are 0.
- R2: A byte is accepted on a clock edge where `in_valid` and `in_ready` are both 1. Accepted bytes of a response that has not yet ended are not visible upstream: `resp_avail` and `out_valid` do not rise because of them.
- R3: An accepted byte with `in_abort` = 1 discards every staged byte of the current response, including itself, even when `in_last` = 1 on the same byte. Afterwards `in_ready` returns to 1 and none of those bytes is ever output.
- R4: An accepted byte with `in_sync_err` = 1 has the same discarding effect as R3, with the same precedence over `in_last`.
- R5: An accepted byte with `in_last` = 1 and neither error flag commits the response. Its bytes then appear on `out_data` unchanged and in arrival order, and responses leave in the order they were committed. `out_last` = 1 on exactly the final byte of each response.
- R6: `resp_avail` is 1 exactly when the output FIFO holds at least one whole committed response, and `out_valid` equals `resp_avail`. A response that is only partly copied never raises either.
- R7: From the edge that accepts an error-free final byte until the commit finishes, `in_ready` is 0. A commit starts only when the output FIFO has free space at least equal to the staged length, so a response is never split and the output FIFO never overflows.
- R8: While the staging buffer holds `STG_DEPTH` bytes, `in_ready` is 0 unless `in_abort` or `in_sync_err` is 1, so a stalled over-long response can still be discarded.
- R9: The count of whole responses goes up by one when a commit finishes and down by one when a byte with `out_last` = 1 is popped. When both happen on the same edge, the count is unchanged.
- R10: While `out_valid` = 1 and `out_ready` = 0, `out_valid` stays 1 and `out_data` and `out_last` are held on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | 8 | Response byte from the bus engine |
| in_last | input | 1 | Byte ends the response |
| in_abort | input | 1 | Bus cycle aborted, drop the staged response |
| in_sync_err | input | 1 | Bus sync error, drop the staged response |
| out_valid | output | 1 | Output byte valid (whole response present) |
| out_ready | input | 1 | Consumer takes the output byte |
| out_data | output | 8 | Output response byte |
| out_last | output | 1 | Output byte ends its response |
| resp_avail | output | 1 | At least one whole response is held |

## Verification
The commit of a new response and the pop of the final byte of an older one can land on the same edge, and the response count must then stay unchanged. The bench places one response in the output FIFO and stages a second. It then starts draining the first after a delay that is swept across every cycle offset through the commit. This way one offset makes the last pop coincide with the commit's final copy. Each case is judged by the flag and by the order and content of both responses popped afterwards. A second pairing is an abort that arrives on the same byte as the end marker. It is covered by the sweep, which places the error flag on every byte position, including the final one.

// File: rtl/resp_stage_pkg.sv
package resp_stage_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_FILL = 2'd0,
    ST_WAIT = 2'd1,
    ST_COPY = 2'd2
  } stage_state_e;
endpackage

// File: rtl/resp_stage_buf.sv
module resp_stage_buf
  import resp_stage_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              clr,
  input  logic [LW-1:0]     rd_idx,
  output logic [BYTE_W-1:0] rd_data,
  output logic [LW-1:0]     len,
  output logic              full
);
  logic [BYTE_W-1:0] mem [DEPTH];

  assign full    = (len == LW'(DEPTH));
  assign rd_data = mem[rd_idx[IW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n)     len <= '0;
    else if (clr)   len <= '0;
    else if (wr_en) len <= len + LW'(1);
  end

  always_ff @(posedge clk) begin
    if (wr_en && !full) mem[len[IW-1:0]] <= wr_data;
  end

  // R3 / R4: a discard leaves the staging buffer empty
  p_clear_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (len == '0));

  // R8: no write lands in a full staging buffer
  p_no_stage_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
endmodule

// File: rtl/resp_out_fifo.sv
module resp_out_fifo
  import resp_stage_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [BYTE_W-1:0] push_data,
  input  logic              push_last,
  input  logic              pop,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_last,
  output logic [CW-1:0]     free
);
  logic [BYTE_W-1:0] mem  [DEPTH];
  logic              ends [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count;

  assign free    = CW'(DEPTH) - count;
  assign rd_data = mem[rd_ptr];
  assign rd_last = ends[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_ptr]  <= push_data;
      ends[wr_ptr] <= push_last;
    end
  end

  // R7: the output store never overflows
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < CW'(DEPTH)));

  // R6: a pop is only offered from a non-empty store
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
endmodule

// File: rtl/resp_commit_ctrl.sv
module resp_commit_ctrl
  import resp_stage_pkg::*;
#(
  parameter int STG_DEPTH = 8,
  parameter int OUT_DEPTH = 16,
  localparam int SLW = $clog2(STG_DEPTH + 1),
  localparam int OCW = $clog2(OUT_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_fire,
  input  logic           in_end,
  input  logic           in_err,
  input  logic [SLW-1:0] stg_len,
  input  logic [OCW-1:0] out_free,
  output logic           busy,
  output logic           stg_wr,
  output logic           stg_clr,
  output logic [SLW-1:0] rd_idx,
  output logic           push,
  output logic           push_last,
  output logic           done
);
  stage_state_e state;
  logic         copy_last;
  logic         room;

  assign room      = int'(out_free) >= int'(stg_len);
  assign copy_last = (rd_idx == stg_len - SLW'(1));
  assign busy      = (state != ST_FILL);

  always_comb begin
    stg_wr    = (state == ST_FILL) && in_fire && !in_err;
    push      = (state == ST_COPY);
    push_last = (state == ST_COPY) && copy_last;
    done      = (state == ST_COPY) && copy_last;
    stg_clr   = ((state == ST_FILL) && in_fire && in_err) || done;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_FILL;
      rd_idx <= '0;
    end else begin
      case (state)
        ST_FILL: if (in_fire && !in_err && in_end) state <= ST_WAIT;
        ST_WAIT: if (room) begin
          state  <= ST_COPY;
          rd_idx <= '0;
        end
        ST_COPY: begin
          rd_idx <= rd_idx + SLW'(1);
          if (copy_last) state <= ST_FILL;
        end
        default: state <= ST_FILL;
      endcase
    end
  end

  // R7: the first copied byte only goes out when the whole response fits
  p_commit_fits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && rd_idx == '0) |-> (int'(out_free) >= int'(stg_len)));

  // R7: no byte is taken while a commit is pending or running
  p_busy_holds_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !stg_wr);
endmodule

// File: rtl/resp_stage_fifo.sv
module resp_stage_fifo
  import resp_stage_pkg::*;
#(
  parameter int STG_DEPTH = 8,
  parameter int OUT_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic       in_abort,
  input  logic       in_sync_err,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_last,
  output logic       resp_avail
);
  localparam int SLW = $clog2(STG_DEPTH + 1);
  localparam int OCW = $clog2(OUT_DEPTH + 1);

  logic           in_err, in_fire, busy;
  logic           stg_wr, stg_clr, stg_full;
  logic [SLW-1:0] stg_len, rd_idx;
  logic [7:0]     stg_byte;
  logic           push, push_last, done, pop;
  logic [OCW-1:0] out_free;
  logic [OCW-1:0] resp_cnt;

  assign in_err     = in_abort | in_sync_err;
  assign in_ready   = !busy && (!stg_full || in_err);
  assign in_fire    = in_valid && in_ready;
  assign resp_avail = (resp_cnt != '0);
  assign out_valid  = resp_avail;
  assign pop        = out_valid && out_ready;

  resp_commit_ctrl #(.STG_DEPTH(STG_DEPTH), .OUT_DEPTH(OUT_DEPTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .in_fire(in_fire), .in_end(in_last),
    .in_err(in_err), .stg_len(stg_len), .out_free(out_free), .busy(busy),
    .stg_wr(stg_wr), .stg_clr(stg_clr), .rd_idx(rd_idx), .push(push),
    .push_last(push_last), .done(done)
  );

  resp_stage_buf #(.DEPTH(STG_DEPTH)) stage_i (
    .clk(clk), .rst_n(rst_n), .wr_en(stg_wr), .wr_data(in_data),
    .clr(stg_clr), .rd_idx(rd_idx), .rd_data(stg_byte), .len(stg_len),
    .full(stg_full)
  );

  resp_out_fifo #(.DEPTH(OUT_DEPTH)) ofifo_i (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(stg_byte),
    .push_last(push_last), .pop(pop), .rd_data(out_data),
    .rd_last(out_last), .free(out_free)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) resp_cnt <= '0;
    else begin
      case ({done, pop && out_last})
        2'b10:   resp_cnt <= resp_cnt + OCW'(1);
        2'b01:   resp_cnt <= resp_cnt - OCW'(1);
        default: resp_cnt <= resp_cnt;
      endcase
    end
  end

  // R6: the flag is only up while the output store holds bytes
  p_avail_backed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_avail |-> (out_free < OCW'(OUT_DEPTH)));

  // R9: a finished commit with no final pop raises the count by one
  p_count_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(pop && out_last)) |=> (resp_cnt == $past(resp_cnt) + OCW'(1)));

  // R9: a final pop and a finished commit on one edge cancel out
  p_count_even_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pop && out_last) |=> (resp_cnt == $past(resp_cnt)));

  // R3 / R4: a discarded byte never adds a whole response
  p_err_no_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_err) |=> (resp_cnt <= $past(resp_cnt)));

  // R10: a withheld pop keeps the byte steady
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
endmodule

// File: tb/resp_stage_fifo_tb_top.sv
`timescale 1ns/1ps
module resp_stage_fifo_tb_top;
  localparam int SD = 4;
  localparam int OD = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_last = 1'b0, in_abort = 1'b0, in_sync_err = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, out_valid, out_last, resp_avail;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;

  int total = 0;
  int bad = 0;
  int exp_resp = 0;
  logic [8:0] exp_q[$];

  always #2.5 clk = ~clk;

  resp_stage_fifo #(.STG_DEPTH(SD), .OUT_DEPTH(OD)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_abort(in_abort),
    .in_sync_err(in_sync_err), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .resp_avail(resp_avail)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // entered and left at a falling edge
  task automatic send_beat(input logic [7:0] d, input bit l, input bit ab, input bit se);
    in_valid = 1'b1; in_data = d; in_last = l; in_abort = ab; in_sync_err = se;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_abort = 1'b0; in_sync_err = 1'b0;
  endtask

  // err_pos >= len means an error-free response
  task automatic send_resp(input int len, input int err_pos, input bit use_sync, input int base);
    for (int i = 0; i < len; i++) begin
      bit e = (i == err_pos);
      chk(resp_avail == (exp_resp != 0), "R2 flag during fill", resp_avail, exp_resp != 0);
      send_beat(8'(base + i), i == len - 1, e && !use_sync, e && use_sync);
      if (e) break;
    end
    if (err_pos >= len)
      for (int i = 0; i < len; i++) exp_q.push_back({i == len - 1, 8'(base + i)});
  endtask

  task automatic wait_commit();
    int n = 0;
    while (!in_ready && n < 60) begin @(negedge clk); n++; end
    chk(in_ready == 1'b1, "R7 commit finishes", in_ready, 1);
    exp_resp++;
  endtask

  task automatic drain_one(input bit hold_first);
    bit fin = 1'b0;
    bit first = 1'b1;
    while (!fin) begin
      logic [8:0] e = exp_q[0];
      chk(out_valid == 1'b1, "R6 out_valid for committed response", out_valid, 1);
      chk(out_data == e[7:0], "R5 byte value", out_data, e[7:0]);
      chk(out_last == e[8], "R5 end marker", out_last, e[8]);
      if (hold_first && first) begin
        @(negedge clk);
        chk(out_valid && out_data == e[7:0] && out_last == e[8], "R10 held byte", out_data, e[7:0]);
      end
      first = 1'b0;
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      void'(exp_q.pop_front());
      fin = e[8];
    end
    exp_resp--;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(resp_avail == 1'b0, "R1 resp_avail after reset", resp_avail, 0);

    // R3 R4 R5: sweep length, error kind and error position (len = none)
    for (int kind = 0; kind < 2; kind++)
      for (int len = 1; len <= SD; len++)
        for (int ep = 0; ep <= len; ep++) begin
          int base = (kind * 128) + (len * 24) + (ep * 5);
          send_resp(len, ep, kind[0], base);
          if (ep < len) begin
            repeat (3) @(negedge clk);
            chk(resp_avail == 1'b0, kind ? "R4 sync error drops" : "R3 abort drops", resp_avail, 0);
            chk(in_ready == 1'b1, kind ? "R4 ready after drop" : "R3 ready after drop", in_ready, 1);
          end else begin
            wait_commit();
            chk(resp_avail == 1'b1, "R6 flag after commit", resp_avail, 1);
            drain_one(len == 2);
            chk(resp_avail == 1'b0, "R6 flag after drain", resp_avail, 0);
          end
        end

    // R8: a full staging buffer only takes an error-flagged byte
    for (int i = 0; i < SD; i++) send_beat(8'(200 + i), 1'b0, 1'b0, 1'b0);
    chk(in_ready == 1'b0, "R8 ready low when staging full", in_ready, 0);
    in_abort = 1'b1;
    #0.1;
    chk(in_ready == 1'b1, "R8 ready for abort when full", in_ready, 1);
    in_abort = 1'b0;
    send_beat(8'd250, 1'b0, 1'b0, 1'b1);
    repeat (2) @(negedge clk);
    chk(resp_avail == 1'b0 && in_ready == 1'b1, "R8 over-long response dropped", resp_avail, 0);

    // R7: commit waits for room in the output store
    send_resp(4, 9, 1'b0, 10); wait_commit();
    send_resp(4, 9, 1'b0, 20); wait_commit();
    send_resp(3, 9, 1'b0, 30);
    repeat (6) @(negedge clk);
    chk(in_ready == 1'b0, "R7 commit stalls while output lacks room", in_ready, 0);
    chk(resp_avail == 1'b1, "R7 earlier responses still available", resp_avail, 1);
    drain_one(1'b0);
    wait_commit();
    drain_one(1'b0);
    drain_one(1'b0);
    chk(resp_avail == 1'b0, "R7 all drained in order", resp_avail, 0);

    // R9: last pop of an older response against a new commit, every offset
    for (int d = 0; d < 8; d++) begin
      send_resp(2, 9, 1'b0, 40 + d * 8);
      wait_commit();
      send_resp(3, 9, 1'b0, 100 + d * 8);
      repeat (d) @(negedge clk);
      drain_one(1'b0);
      wait_commit();
      chk(resp_avail == 1'b1, "R9 count kept across coincident pop and commit", resp_avail, 1);
      drain_one(1'b0);
      chk(resp_avail == 1'b0, "R9 count back to zero", resp_avail, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule